// File: doc/BRIEF.md
# Bank Auto-Precharge Timer

This block follows a single SDRAM bank from the controller's point of view. It accepts single-cycle activate, read and write strobes, each column strobe qualified by an auto-precharge flag, and works out the exact cycle in which the bank's internal precharge begins. It also reports when the bank may take its next activate. All timing limits come in on static configuration ports as whole clock counts (nanosecond values already rounded up). These limits are additive latency, CAS latency, burst length (4 or 8), write recovery, and the row-active, read-to-precharge, precharge and row-cycle minimums.

For a read with auto-precharge, the start edge is not a fixed delay. The nominal point is pushed later when the read-to-precharge minimum or the row-active minimum since the last activate has not yet run out. For a write with auto-precharge, the start waits for the end of the write burst plus write recovery. The new-activate permission combines the precharge time, counted from the internal precharge start, with the row-cycle time, counted from the previous activate.

Strobes are sampled on the rising clock edge. Every output is derived from registered state. "A delay of N cycles" means the output is high in the cycle that lies N cycles after the cycle in which the command strobe was high.

Top module: `bank_ap_timer`

## Requirements
- R1: A read or write strobe with the auto-precharge flag low, to an open bank, leaves the bank open and produces no precharge start.
- R2: A read with the flag high (BL chosen by `cfgBl8`: 0 = 4, 1 = 8) starts precharge at the nominal delay AL + BL/2 when no other limit applies. With AL=1, BL=4 and tRTP=2 this is 3 cycles.
- R3: If fewer than tRAS cycles have passed since the activate at the nominal point, the precharge start moves to the first cycle that lies tRAS cycles after the activate.
- R4: A read precharge never starts before AL + BL/2 − 2 + tRTP cycles after the read. With tRTP=4 this is 5 cycles for BL4 and 7 cycles for BL8.
- R5: With tRAS and tRC not limiting, the first cycle with `actOk` high after a read with auto-precharge lies AL + tRTP + tRP cycles later for BL4, and AL + 2 + tRTP + tRP cycles later for BL8.
- R6: A tRTP below 2 acts as 2, so precharge never starts earlier than two cycles after the last 4-beat prefetch. With tRTP=1 the delay is AL+2 (BL4) or AL+4 (BL8).
- R7: A write with the flag high starts precharge AL + CL − 1 + BL/2 + WR cycles after the write, or later if tRAS is not yet met.
- R8: `actOk` is high only when the bank is closed, no precharge is pending, at least tRP cycles have passed since the precharge start, and at least tRC cycles have passed since the last activate. It is high after reset.
- R9: `bankOpen` rises the cycle after an accepted activate and falls the cycle after `preStart`.
- R10: An activate while `actOk` is low, a read or write while the bank is closed or has a precharge pending, or more than one strobe in a cycle, sets the sticky `protoErr` flag and is otherwise ignored. Only reset clears the flag.
- R11: Each accepted auto-precharge command yields exactly one single-cycle `preStart` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAl | input | CW | Additive latency, cycles |
| cfgCl | input | CW | CAS latency, cycles |
| cfgBl8 | input | 1 | Burst length select, 1 = 8, 0 = 4 |
| cfgWr | input | CW | Write recovery, cycles |
| cfgRas | input | CW | Minimum row-active time, cycles |
| cfgRtp | input | CW | Minimum read-to-precharge time, cycles |
| cfgRp | input | CW | Precharge time, cycles |
| cfgRc | input | CW | Row-cycle time, cycles |
| actStb | input | 1 | Activate strobe |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| apFlag | input | 1 | Auto-precharge request qualifying rdStb/wrStb |
| preStart | output | 1 | Internal precharge begins this cycle |
| bankOpen | output | 1 | Row open or precharge still pending |
| actOk | output | 1 | An activate would be accepted this cycle |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
Two cases can meet in one cycle. In the first, the tRAS limit runs out in the same cycle as the read's nominal start point. The bench provokes this by placing the read-with-precharge so that the activate-to-nominal distance equals tRAS exactly, then judges that `preStart` appears in that one cycle and only once. In the second, the tRP and tRC windows expire together. The bench lines them up by issuing the read one cycle after the activate, with tRC = tRAS + tRP, and judges that `actOk` rises in the shared cycle and not one cycle early. A behavioural reference model built on absolute cycle numbers is compared against every output in every cycle, and the measured distances are also checked against values worked out by hand.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

  typedef struct packed {
    logic actTake;   // accepted activate
    logic rdApTake;  // accepted read with auto-precharge
    logic wrApTake;  // accepted write with auto-precharge
    logic preFire;   // internal precharge starts this cycle
  } apStrobe_t;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_PEND = 2'd2
  } bankState_t;

endpackage

// File: rtl/bank_ap_elapsed.sv
module bank_ap_elapsed #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT = '1;
  localparam logic [W-1:0] ONE = W'(1);

  // Cycles since the last restart, saturating; reset means "long ago".
  always_ff @(posedge clk) begin
    if (!rstN)            count <= SAT;
    else if (restart)     count <= ONE;
    else if (count != SAT) count <= count + ONE;
  end
endmodule

// File: rtl/bank_ap_dp.sv
module bank_ap_dp
  import bank_ap_pkg::*;
#(
  parameter int CW = 6,
  parameter int TW = CW + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] cfgAl,
  input  logic [CW-1:0] cfgCl,
  input  logic          cfgBl8,
  input  logic [CW-1:0] cfgWr,
  input  logic [CW-1:0] cfgRas,
  input  logic [CW-1:0] cfgRtp,
  input  logic [CW-1:0] cfgRp,
  input  logic [CW-1:0] cfgRc,
  input  apStrobe_t     stb,
  output logic          nomDone,
  output logic          rasMet,
  output logic          rpMet,
  output logic          rcMet
);
  localparam int NUM_SINCE = 2;          // [0] since activate, [1] since precharge
  localparam logic [TW-1:0] ONE   = TW'(1);
  localparam logic [TW-1:0] TWO   = TW'(2);
  localparam logic [TW-1:0] THREE = TW'(3);
  localparam logic [TW-CW-1:0] PAD = '0;

  logic [TW-1:0] alX, clX, wrX, rasX, rtpX, rpX, rcX;
  logic [TW-1:0] rtpEff, rdDelay, wrDelay, nomLeft;
  logic [NUM_SINCE-1:0] restartV;
  logic [TW-1:0] elapsed [NUM_SINCE];

  assign alX  = {PAD, cfgAl};
  assign clX  = {PAD, cfgCl};
  assign wrX  = {PAD, cfgWr};
  assign rasX = {PAD, cfgRas};
  assign rtpX = {PAD, cfgRtp};
  assign rpX  = {PAD, cfgRp};
  assign rcX  = {PAD, cfgRc};

  // Read: last prefetch + 2 is the floor, tRTP may push beyond it.
  assign rtpEff  = (rtpX < TWO) ? TWO : rtpX;
  assign rdDelay = alX + (cfgBl8 ? TWO : '0) + rtpEff;
  // Write: WL + BL/2 + WR, WL = AL + CL - 1, folded to avoid underflow.
  assign wrDelay = alX + clX + wrX + (cfgBl8 ? THREE : ONE);

  always_ff @(posedge clk) begin
    if (!rstN)              nomLeft <= '0;
    else if (stb.rdApTake)  nomLeft <= rdDelay - ONE;
    else if (stb.wrApTake)  nomLeft <= wrDelay - ONE;
    else if (nomLeft != '0) nomLeft <= nomLeft - ONE;
  end

  assign restartV = {stb.preFire, stb.actTake};

  for (genvar g = 0; g < NUM_SINCE; g++) begin : g_since
    bank_ap_elapsed #(.W(TW)) u_el (
      .clk     (clk),
      .rstN    (rstN),
      .restart (restartV[g]),
      .count   (elapsed[g])
    );
  end

  assign nomDone = (nomLeft == '0);
  assign rasMet  = (elapsed[0] >= rasX);
  assign rcMet   = (elapsed[0] >= rcX);
  assign rpMet   = (elapsed[1] >= rpX);
endmodule

// File: rtl/bank_ap_ctrl.sv
module bank_ap_ctrl
  import bank_ap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      actStb,
  input  logic      rdStb,
  input  logic      wrStb,
  input  logic      apFlag,
  input  logic      nomDone,
  input  logic      rasMet,
  input  logic      rpMet,
  input  logic      rcMet,
  output apStrobe_t stb,
  output logic      preStart,
  output logic      bankOpen,
  output logic      actOk,
  output logic      protoErr
);
  bankState_t state, stateNxt;
  logic multi, colCmd, colLegal, errNow;

  assign preStart = (state == BK_PEND) && nomDone && rasMet;
  assign actOk    = (state == BK_IDLE) && rpMet && rcMet;
  assign bankOpen = (state != BK_IDLE);

  assign multi    = (actStb & rdStb) | (actStb & wrStb) | (rdStb & wrStb);
  assign colCmd   = rdStb | wrStb;
  assign colLegal = (state == BK_OPEN);
  assign errNow   = multi | (actStb & ~actOk) | (colCmd & ~colLegal);

  always_comb begin
    stb.actTake  = actStb & ~multi & actOk;
    stb.rdApTake = rdStb & ~multi & colLegal & apFlag;
    stb.wrApTake = wrStb & ~multi & colLegal & apFlag;
    stb.preFire  = preStart;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      BK_IDLE: if (stb.actTake) stateNxt = BK_OPEN;
      BK_OPEN: if (stb.rdApTake || stb.wrApTake) stateNxt = BK_PEND;
      BK_PEND: if (preStart) stateNxt = BK_IDLE;
      default: stateNxt = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BK_IDLE;
      protoErr <= 1'b0;
    end else begin
      state    <= stateNxt;
      protoErr <= protoErr | errNow;
    end
  end
endmodule

// File: rtl/bank_ap_timer.sv
module bank_ap_timer
  import bank_ap_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] cfgAl,
  input  logic [CW-1:0] cfgCl,
  input  logic          cfgBl8,
  input  logic [CW-1:0] cfgWr,
  input  logic [CW-1:0] cfgRas,
  input  logic [CW-1:0] cfgRtp,
  input  logic [CW-1:0] cfgRp,
  input  logic [CW-1:0] cfgRc,
  input  logic          actStb,
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic          apFlag,
  output logic          preStart,
  output logic          bankOpen,
  output logic          actOk,
  output logic          protoErr
);
  localparam int TW = CW + 3;

  apStrobe_t stb;
  logic nomDone, rasMet, rpMet, rcMet;

  bank_ap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .actStb   (actStb),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .apFlag   (apFlag),
    .nomDone  (nomDone),
    .rasMet   (rasMet),
    .rpMet    (rpMet),
    .rcMet    (rcMet),
    .stb      (stb),
    .preStart (preStart),
    .bankOpen (bankOpen),
    .actOk    (actOk),
    .protoErr (protoErr)
  );

  bank_ap_dp #(.CW(CW), .TW(TW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgAl   (cfgAl),
    .cfgCl   (cfgCl),
    .cfgBl8  (cfgBl8),
    .cfgWr   (cfgWr),
    .cfgRas  (cfgRas),
    .cfgRtp  (cfgRtp),
    .cfgRp   (cfgRp),
    .cfgRc   (cfgRc),
    .stb     (stb),
    .nomDone (nomDone),
    .rasMet  (rasMet),
    .rpMet   (rpMet),
    .rcMet   (rcMet)
  );
endmodule

// File: rtl/bank_ap_timer_chk.sv
module bank_ap_timer_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] cfgRp,
  input logic          actStb,
  input logic          rdStb,
  input logic          wrStb,
  input logic          preStart,
  input logic          bankOpen,
  input logic          actOk,
  input logic          protoErr
);
  localparam int KW = CW + 3;
  localparam logic [KW-1:0] KSAT = '1;
  localparam logic [KW-CW-1:0] KPAD = '0;

  logic [KW-1:0] sincePre;
  always_ff @(posedge clk) begin
    if (!rstN)                sincePre <= KSAT;
    else if (preStart)        sincePre <= KW'(1);
    else if (sincePre != KSAT) sincePre <= sincePre + KW'(1);
  end

  p_pre_open_r9: assert property (@(posedge clk) disable iff (!rstN)
    preStart |-> bankOpen);
  p_pre_close_r9: assert property (@(posedge clk) disable iff (!rstN)
    preStart |=> !bankOpen);
  p_act_take_r9: assert property (@(posedge clk) disable iff (!rstN)
    (actStb && actOk && !rdStb && !wrStb) |=> bankOpen);
  p_pre_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    preStart |=> !preStart);
  p_ok_closed_r8: assert property (@(posedge clk) disable iff (!rstN)
    actOk |-> !bankOpen);
  p_ok_rp_r8: assert property (@(posedge clk) disable iff (!rstN)
    actOk |-> (sincePre >= {KPAD, cfgRp}));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
  p_bad_act_r10: assert property (@(posedge clk) disable iff (!rstN)
    (actStb && !actOk) |=> protoErr);
endmodule

bind bank_ap_timer bank_ap_timer_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgRp    (cfgRp),
  .actStb   (actStb),
  .rdStb    (rdStb),
  .wrStb    (wrStb),
  .preStart (preStart),
  .bankOpen (bankOpen),
  .actOk    (actOk),
  .protoErr (protoErr)
);

// File: tb/bank_ap_timer_tb.sv
module bank_ap_timer_tb;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgAl, cfgCl, cfgWr, cfgRas, cfgRtp, cfgRp, cfgRc;
  logic cfgBl8;
  logic actStb = 0, rdStb = 0, wrStb = 0, apFlag = 0;
  logic preStart, bankOpen, actOk, protoErr;

  always #5 clk = ~clk;

  bank_ap_timer #(.CW(CW)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgAl(cfgAl), .cfgCl(cfgCl), .cfgBl8(cfgBl8), .cfgWr(cfgWr),
    .cfgRas(cfgRas), .cfgRtp(cfgRtp), .cfgRp(cfgRp), .cfgRc(cfgRc),
    .actStb(actStb), .rdStb(rdStb), .wrStb(wrStb), .apFlag(apFlag),
    .preStart(preStart), .bankOpen(bankOpen), .actOk(actOk), .protoErr(protoErr)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state (absolute cycle numbers)
  int cyc, curCyc, mDue, mLastAct, mLastPre;
  bit mOpen, mPend, mErr;
  bit sawPre, sawOk;
  int preCount;

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, actual, expected, curCyc);
    end
  endtask

  function automatic int rdDelay();
    int rtp = (cfgRtp < 2) ? 2 : int'(cfgRtp);
    return int'(cfgAl) + (cfgBl8 ? 4 : 2) - 2 + rtp;
  endfunction

  function automatic int wrDelay();
    return int'(cfgAl) + int'(cfgCl) - 1 + (cfgBl8 ? 4 : 2) + int'(cfgWr);
  endfunction

  task automatic doReset(input int al, cl, bl8, wr, ras, rtp, rp, rc);
    @(negedge clk);
    rstN = 0; actStb = 0; rdStb = 0; wrStb = 0; apFlag = 0;
    cfgAl = CW'(al); cfgCl = CW'(cl); cfgBl8 = bl8[0]; cfgWr = CW'(wr);
    cfgRas = CW'(ras); cfgRtp = CW'(rtp); cfgRp = CW'(rp); cfgRc = CW'(rc);
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc = 0; mOpen = 0; mPend = 0; mErr = 0; mDue = 0;
    mLastAct = -1000; mLastPre = -1000;
  endtask

  task automatic step(input bit a, input bit r, input bit w, input bit ap);
    bit ePre, eOk;
    @(negedge clk);
    actStb = a; rdStb = r; wrStb = w; apFlag = ap;
    #1;
    curCyc = cyc;
    ePre = mPend && (cyc >= mDue) && (cyc - mLastAct >= int'(cfgRas));
    eOk  = !mOpen && !mPend && (cyc - mLastPre >= int'(cfgRp)) &&
           (cyc - mLastAct >= int'(cfgRc));
    chk(preStart == ePre, "R3 preStart", preStart, ePre);
    chk(bankOpen == mOpen, "R9 bankOpen", bankOpen, mOpen);
    chk(actOk == eOk, "R8 actOk", actOk, eOk);
    chk(protoErr == mErr, "R10 protoErr", protoErr, mErr);
    sawPre = preStart; sawOk = actOk;
    if (preStart) preCount++;
    if (int'(a) + int'(r) + int'(w) > 1) mErr = 1;
    else if (a) begin
      if (eOk) begin mOpen = 1; mLastAct = cyc; end
      else mErr = 1;
    end else if (r || w) begin
      if (mOpen && !mPend) begin
        if (ap) begin mPend = 1; mDue = cyc + (r ? rdDelay() : wrDelay()); end
      end else mErr = 1;
    end
    if (ePre) begin mPend = 0; mOpen = 0; mLastPre = cyc; end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic waitPre(input int from, output int d);
    d = -1;
    for (int i = 0; i < 200; i++) begin
      step(0, 0, 0, 0);
      if (sawPre) begin d = curCyc - from; break; end
    end
  endtask

  task automatic waitOk(input int from, output int d);
    d = -1;
    for (int i = 0; i < 200; i++) begin
      step(0, 0, 0, 0);
      if (sawOk) begin d = curCyc - from; break; end
    end
  endtask

  // activate, wait gap idle cycles, then column command; returns its cycle
  task automatic actThen(input int gap, input bit isWr, input bit ap, output int cmdCyc);
    step(1, 0, 0, 0);
    idle(gap);
    step(0, !isWr, isWr, ap);
    cmdCyc = curCyc;
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, d, p0;
    // config A: AL1 CL3 BL4 WR3 RAS8 RTP2 RP3 RC11
    doReset(1, 3, 0, 3, 8, 2, 3, 11);
    step(0, 0, 0, 0);
    chk(actOk == 1, "R8 reset actOk", actOk, 1);
    chk(bankOpen == 0, "R9 reset bankOpen", bankOpen, 0);
    chk(protoErr == 0 && preStart == 0, "R10 reset flags", protoErr, 0);

    // R2 nominal read precharge, R5 read-to-activate BL4
    actThen(10, 0, 1, c);
    waitPre(c, d);  chk(d == 3, "R2 read nominal delay", d, 3);
    waitOk(c, d);   chk(d == 6, "R5 BL4 read-to-activate", d, 6);

    // R3 tRAS push: read right after activate
    actThen(0, 0, 1, c);
    waitPre(c, d);  chk(d == 7, "R3 tRAS pushed start", d, 7);
    waitOk(c, d);   chk(d == 10, "R8 tRP/tRC joint", d, 10);

    // coincidence: tRAS ends on the nominal edge; R11 single pulse
    p0 = preCount;
    actThen(4, 0, 1, c);
    waitPre(c, d);  chk(d == 3, "R3 tRAS equals nominal", d, 3);
    waitOk(c, d);
    chk(preCount - p0 == 1, "R11 single pulse", preCount - p0, 1);

    // R1 no auto-precharge: bank stays open
    p0 = preCount;
    step(1, 0, 0, 0);
    step(0, 1, 0, 0); step(0, 0, 1, 0);
    idle(20);
    chk(preCount == p0, "R1 no precharge", preCount - p0, 0);
    chk(bankOpen == 1, "R1 bank still open", bankOpen, 1);
    step(0, 1, 0, 1); c = curCyc;
    waitPre(c, d);  chk(d == 3, "R1 later AP read", d, 3);
    waitOk(c, d);

    // R7 write with auto-precharge: 1+3-1+2+3 = 8
    actThen(10, 1, 1, c);
    waitPre(c, d);  chk(d == 8, "R7 write delay", d, 8);
    waitOk(c, d);

    // R10 read to closed bank, then ignored second activate
    step(0, 1, 0, 1);
    step(0, 0, 0, 0);
    chk(protoErr == 1, "R10 err set", protoErr, 1);
    chk(bankOpen == 0, "R10 closed read ignored", bankOpen, 0);
    idle(2);
    step(1, 0, 0, 0); idle(5);
    step(1, 0, 0, 0);                 // rejected: must not restart tRAS
    step(0, 1, 0, 1); c = curCyc;
    waitPre(c, d);  chk(d == 3, "R10 rejected act ignored", d, 3);
    waitOk(c, d);
    step(1, 1, 0, 0);                 // two strobes: ignored
    step(0, 0, 0, 0);
    chk(bankOpen == 0, "R10 multi strobe ignored", bankOpen, 0);

    // R4/R5 tRTP push, BL4: AL1 RTP4
    doReset(1, 3, 0, 3, 8, 4, 3, 11);
    actThen(10, 0, 1, c);
    waitPre(c, d);  chk(d == 5, "R4 BL4 tRTP push", d, 5);
    waitOk(c, d);   chk(d == 8, "R5 BL4 tRTP+tRP", d, 8);

    // R4/R5 BL8
    doReset(1, 3, 1, 3, 8, 4, 3, 11);
    actThen(10, 0, 1, c);
    waitPre(c, d);  chk(d == 7, "R4 BL8 tRTP push", d, 7);
    waitOk(c, d);   chk(d == 10, "R5 BL8 read-to-activate", d, 10);
    actThen(10, 1, 1, c);
    waitPre(c, d);  chk(d == 10, "R7 BL8 write delay", d, 10);
    waitOk(c, d);

    // R6 tRTP below two clocks
    doReset(1, 3, 0, 3, 8, 1, 3, 11);
    actThen(10, 0, 1, c);
    waitPre(c, d);  chk(d == 3, "R6 BL4 prefetch floor", d, 3);
    waitOk(c, d);
    doReset(1, 3, 1, 3, 8, 1, 3, 11);
    actThen(10, 0, 1, c);
    waitPre(c, d);  chk(d == 5, "R6 BL8 prefetch floor", d, 5);
    waitOk(c, d);

    // R8 tRC dominant
    doReset(1, 3, 0, 3, 8, 2, 3, 20);
    actThen(0, 0, 1, c);
    waitPre(c, d);  chk(d == 7, "R3 push with long tRC", d, 7);
    waitOk(c, d);   chk(d == 19, "R8 tRC limits activate", d, 19);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule